// File: doc/BRIEF.md
# Dual Down-Counter Timer Pair with Shared Interrupt

This block places two identical down-counting timers behind one 4 KB register window. A single bus port carries reads and writes. The address picks the timer: byte addresses below 0x20 go to the first timer. Byte addresses from 0x20 to 0x3F go to the second timer, which receives the address with 0x20 removed. Every other address in the window reads as zero and discards writes.

Both timers take the same base tick enable, `tick_i`, which nominally pulses at 1 MHz. Each timer divides that tick by its own prescaler. It then counts down in free-running, periodic or single-shot fashion and raises an interrupt status when its count reaches zero. The block stores each timer's enabled interrupt level on its own and drives one interrupt output, which is the OR of the two levels. Clearing one timer therefore never hides an interrupt still pending on the other.

Read data is registered. It appears one cycle after the request, together with a one-cycle valid strobe.

Top module: `dual_timer`

## Requirements
- R1: After reset `irq_o` and `rvalid_o` are low. Each timer's control register (offset 0x08) reads 0x20, with only the interrupt-enable bit set. The reload value (0x00) and the count (0x04) read 0.
- R2: Byte addresses 0x00 to 0x1F reach timer 0. Addresses 0x20 to 0x3F reach timer 1 at the address minus 0x20. A write to one timer leaves the other timer unchanged.
- R3: Addresses 0x40 to 0xFFF read 0 and ignore writes. Inside a timer, the unused offset 0x1C and any non-word-aligned offset also read 0 and ignore writes.
- R4: A read sets `rvalid_o` high for exactly the next cycle, with `rdata_o` valid in that same cycle. A write never sets `rvalid_o`.
- R5: A write to offset 0x00 sets both the reload value and the count. A write to offset 0x18 sets only the reload value. Both offsets read back the reload value.
- R6: Control bit 7 enables counting. Control bits 3:2 select the divider: 0 gives 1, 1 gives 16, 2 gives 256, and 3 gives 1. Each divided tick decrements the count by one. A control write restarts the divider phase.
- R7: When the count steps from 1 to 0, the raw status (offset 0x10, bit 0) is set. The masked status (offset 0x14) reads raw status AND control bit 5. Any write to offset 0x0C clears the raw status. A set in the same cycle wins over the clear.
- R8: A divided tick that finds the count at 0 reloads it. With control bit 6 set, the new count is the reload value. With bit 6 clear, the new count is 0xFFFF, or 0xFFFFFFFF when control bit 1 is set. Control bit 1 clear also limits the count to 16 bits.
- R9: With control bit 0 set, the step to zero also clears control bit 7, so the count stays at 0.
- R10: `irq_o` rises one cycle after either timer's masked status goes high. It stays high while either masked status is high, and it falls one cycle after both are low.
- R11: Writes to the count register (offset 0x04) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick enable shared by both timers |
| sel_i | input | 1 | Bus access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (12) | Byte address inside the window |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | OR of both timers' enabled interrupt levels |

## Verification
The bench builds the block with its default parameters:
- two timers, a 12-bit address and 32-bit data;
- so the full 0x000 to 0xFFF window is reachable, including both ends of the unused region above 0x40;
- so both the 16-bit and 32-bit free-running wrap values are observable.

The bench drives `tick_i` only in counted bursts. This keeps every count exact. It also lets the divide-by-16 and divide-by-256 boundaries be checked one tick before and one tick after they fall. The bench drives the two timers with different reload values, so one interrupt can be cleared while the other is still pending.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int OFF_W = 5;
  localparam int PRE_W = 8;

  localparam logic [OFF_W-1:0] OFF_LOAD = 5'h00;
  localparam logic [OFF_W-1:0] OFF_CNT  = 5'h04;
  localparam logic [OFF_W-1:0] OFF_CTRL = 5'h08;
  localparam logic [OFF_W-1:0] OFF_CLR  = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_RAW  = 5'h10;
  localparam logic [OFF_W-1:0] OFF_MSK  = 5'h14;
  localparam logic [OFF_W-1:0] OFF_BG   = 5'h18;

  typedef enum logic [1:0] {
    DIV_1   = 2'd0,
    DIV_16  = 2'd1,
    DIV_256 = 2'd2,
    DIV_RSV = 2'd3
  } div_e;

  typedef struct packed {
    logic en;
    logic periodic;
    logic ie;
    logic rsvd;
    div_e div;
    logic wide;
    logic oneshot;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 8'h20;
endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode import dtmr_pkg::*; #(
  parameter int ADDR_W  = 12,
  parameter int NUM_TMR = 2
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_TMR-1:0] hit_o,
  output logic [OFF_W-1:0]   off_o
);
  localparam int IDX_W = ADDR_W - OFF_W;

  logic [IDX_W-1:0] idx;
  assign idx   = addr_i[ADDR_W-1:OFF_W];
  assign off_o = addr_i[OFF_W-1:0];

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_hit
    assign hit_o[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/dtmr_unit.sv
module dtmr_unit import dtmr_pkg::*; #(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  localparam logic [DW-1:0] NARROW_MASK = DW'(16'hFFFF);

  ctrl_t           ctrl_q;
  logic [DW-1:0]   load_q, cnt_q;
  logic            raw_q;
  logic [PRE_W-1:0] pre_q;

  logic wr_load, wr_bg, wr_ctrl, wr_clr;
  logic pre_hit, step, hit_zero;
  logic [DW-1:0] mask, cnt_m, wrap_val, cnt_nxt;

  assign wr_load = wr_i && (off_i == OFF_LOAD);
  assign wr_bg   = wr_i && (off_i == OFF_BG);
  assign wr_ctrl = wr_i && (off_i == OFF_CTRL);
  assign wr_clr  = wr_i && (off_i == OFF_CLR);

  always_comb begin
    unique case (ctrl_q.div)
      DIV_16:  pre_hit = tick_i && (pre_q[3:0] == 4'hF);
      DIV_256: pre_hit = tick_i && (&pre_q);
      default: pre_hit = tick_i;
    endcase
  end

  assign step     = pre_hit && ctrl_q.en;
  assign mask     = ctrl_q.wide ? '1 : NARROW_MASK;
  assign cnt_m    = cnt_q & mask;
  assign wrap_val = ctrl_q.periodic ? load_q : mask;
  assign cnt_nxt  = (cnt_m == '0) ? wrap_val : (cnt_m - DW'(1));
  assign hit_zero = step && (cnt_m == DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      cnt_q  <= '0;
      raw_q  <= 1'b0;
      pre_q  <= '0;
    end else begin
      if (wr_ctrl)     pre_q <= '0;
      else if (tick_i) pre_q <= pre_q + PRE_W'(1);

      if (wr_load || wr_bg) load_q <= wdata_i;

      if (wr_load)   cnt_q <= wdata_i;
      else if (step) cnt_q <= cnt_nxt;

      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[7:0]);
      else if (hit_zero && ctrl_q.oneshot) ctrl_q.en <= 1'b0;

      if (hit_zero)    raw_q <= 1'b1;
      else if (wr_clr) raw_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_LOAD, OFF_BG: rdata_o = load_q;
      OFF_CNT:          rdata_o = cnt_m;
      OFF_CTRL:         rdata_o = DW'(ctrl_q);
      OFF_RAW:          rdata_o = DW'(raw_q);
      OFF_MSK:          rdata_o = DW'(raw_q & ctrl_q.ie);
      default:          rdata_o = '0;
    endcase
  end

  assign irq_o = raw_q & ctrl_q.ie;

  AST_RAW_ONLY_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> ($past(cnt_m) == DW'(1))); // R7
  AST_CLR_DROPS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !hit_zero) |=> !raw_q); // R7
  AST_ONESHOT_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_zero && ctrl_q.oneshot && !wr_ctrl) |=> !ctrl_q.en); // R9
  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (cnt_m == '0) && ctrl_q.periodic && ctrl_q.wide && !wr_load)
      |=> (cnt_q == $past(load_q))); // R8
endmodule

// File: rtl/dtmr_irq_merge.sv
module dtmr_irq_merge #(
  parameter int NUM_TMR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TMR-1:0] src_i,
  output logic               irq_o
);
  logic [NUM_TMR-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= src_i;
  end

  assign irq_o = |lvl_q;

  AST_IRQ_FOLLOWS_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> irq_o); // R10
  AST_IRQ_QUIET_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|src_i) |=> !irq_o); // R10
endmodule

// File: rtl/dual_timer.sv
module dual_timer import dtmr_pkg::*; #(
  parameter int ADDR_W  = 12,
  parameter int DW      = 32,
  parameter int NUM_TMR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic [NUM_TMR-1:0] hit, unit_irq;
  logic [OFF_W-1:0]   off;
  logic [DW-1:0]      rd_arr [NUM_TMR];
  logic [DW-1:0]      rd_mux;
  logic               rd_req;

  dtmr_decode #(.ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .off_o  (off)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dtmr_unit #(.DW(DW)) u_unit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .wr_i    (sel_i && wr_i && hit[g]),
      .off_i   (off),
      .wdata_i (wdata_i),
      .rdata_o (rd_arr[g]),
      .irq_o   (unit_irq[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (hit[i]) rd_mux = rd_arr[i];
    end
  end

  assign rd_req = sel_i && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_mux;
    end
  end

  dtmr_irq_merge #(.NUM_TMR(NUM_TMR)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (unit_irq),
    .irq_o  (irq_o)
  );

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(sel_i && !wr_i)); // R4
  AST_WRITE_NO_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i) |=> !rvalid_o); // R4
  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && !(|hit)) |=> (rdata_o == '0)); // R3
endmodule

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] d;
  logic        v;

  always #2 clk_i = ~clk_i;

  dual_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; sel_i = 1'b0; wr_i = 1'b0; tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic bwr(logic [11:0] a, logic [31:0] data);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = data;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic brd(logic [11:0] a);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    sel_i = 1'b0;
    v = rvalid_o;
    d = rdata_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
    end
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 rvalid", {31'b0, rvalid_o}, 32'h0);
    brd(12'h008); check("R1 ctrl t0", d, 32'h20);
    brd(12'h028); check("R1 ctrl t1", d, 32'h20);
    brd(12'h000); check("R1 load", d, 32'h0);
    brd(12'h004); check("R1 count", d, 32'h0);
  endtask

  task automatic t_steer();
    do_reset();
    bwr(12'h000, 32'h11);
    bwr(12'h020, 32'h22);
    brd(12'h000); check("R2 t0 load", d, 32'h11);
    brd(12'h020); check("R2 t1 load", d, 32'h22);
    bwr(12'h038, 32'h33);
    brd(12'h018); check("R2 t0 untouched", d, 32'h11);
    brd(12'h038); check("R2 t1 bg", d, 32'h33);
  endtask

  task automatic t_window();
    bwr(12'h040, 32'h55);
    bwr(12'hFFC, 32'h66);
    bwr(12'h01C, 32'h77);
    bwr(12'h001, 32'h88);
    brd(12'h040); check("R3 0x40 reads 0", d, 32'h0);
    brd(12'hFFC); check("R3 0xFFC reads 0", d, 32'h0);
    brd(12'h01C); check("R3 0x1C reads 0", d, 32'h0);
    brd(12'h001); check("R3 unaligned reads 0", d, 32'h0);
    brd(12'h000); check("R3 t0 load kept", d, 32'h11);
    brd(12'h020); check("R3 t1 load kept", d, 32'h33);
  endtask

  task automatic t_latency();
    do_reset();
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = 12'h008;
    check("R4 no early valid", {31'b0, rvalid_o}, 32'h0);
    @(negedge clk_i);
    sel_i = 1'b0;
    check("R4 valid next cycle", {31'b0, rvalid_o}, 32'h1);
    check("R4 data with valid", rdata_o, 32'h20);
    @(negedge clk_i);
    check("R4 valid one cycle", {31'b0, rvalid_o}, 32'h0);
    bwr(12'h000, 32'h5);
    check("R4 write no valid", {31'b0, rvalid_o}, 32'h0);
  endtask

  task automatic t_loads();
    do_reset();
    bwr(12'h000, 32'd7);
    brd(12'h004); check("R5 load sets count", d, 32'd7);
    bwr(12'h018, 32'd20);
    brd(12'h004); check("R5 bg keeps count", d, 32'd7);
    brd(12'h000); check("R5 load reads reload", d, 32'd20);
    bwr(12'h008, 32'hC2);
    ticks(8);
    brd(12'h004); check("R5 bg used on reload", d, 32'd20);
  endtask

  task automatic t_prescale();
    do_reset();
    bwr(12'h000, 32'd10);
    bwr(12'h008, 32'h86);
    ticks(15); brd(12'h004); check("R6 div16 before", d, 32'd10);
    ticks(1);  brd(12'h004); check("R6 div16 at", d, 32'd9);
    bwr(12'h008, 32'h06);
    ticks(16); brd(12'h004); check("R6 disabled holds", d, 32'd9);
    bwr(12'h000, 32'd5);
    bwr(12'h008, 32'h8A);
    ticks(255); brd(12'h004); check("R6 div256 before", d, 32'd5);
    ticks(1);   brd(12'h004); check("R6 div256 at", d, 32'd4);
    bwr(12'h008, 32'h8E);
    ticks(2); brd(12'h004); check("R6 div code 3 is 1", d, 32'd2);
  endtask

  task automatic t_status();
    do_reset();
    bwr(12'h000, 32'd1);
    bwr(12'h008, 32'hC2);
    ticks(1);
    @(negedge clk_i);
    brd(12'h010); check("R7 raw set", d, 32'h1);
    brd(12'h014); check("R7 masked off", d, 32'h0);
    check("R7 irq masked", {31'b0, irq_o}, 32'h0);
    bwr(12'h008, 32'h62);
    brd(12'h014); check("R7 masked on", d, 32'h1);
    check("R7 irq on", {31'b0, irq_o}, 32'h1);
    bwr(12'h00C, 32'h0);
    brd(12'h010); check("R7 raw cleared", d, 32'h0);
  endtask

  task automatic t_modes();
    do_reset();
    bwr(12'h000, 32'd2);
    bwr(12'h008, 32'h80);
    ticks(3); brd(12'h004); check("R8 16-bit wrap", d, 32'h0000FFFF);
    ticks(1); brd(12'h004); check("R8 16-bit after wrap", d, 32'h0000FFFE);
    do_reset();
    bwr(12'h000, 32'd1);
    bwr(12'h008, 32'h82);
    ticks(2); brd(12'h004); check("R8 32-bit wrap", d, 32'hFFFFFFFF);
    do_reset();
    bwr(12'h000, 32'd3);
    bwr(12'h008, 32'hC2);
    ticks(4); brd(12'h004); check("R8 periodic reload", d, 32'd3);
  endtask

  task automatic t_oneshot();
    do_reset();
    bwr(12'h000, 32'd2);
    bwr(12'h008, 32'hC3);
    ticks(2);
    brd(12'h008); check("R9 enable cleared", d, 32'h43);
    ticks(3);
    brd(12'h004); check("R9 stays zero", d, 32'h0);
  endtask

  task automatic t_merge();
    do_reset();
    bwr(12'h000, 32'd2); bwr(12'h008, 32'hE2);
    bwr(12'h020, 32'd4); bwr(12'h028, 32'hE2);
    ticks(2);
    @(negedge clk_i);
    check("R10 irq from t0", {31'b0, irq_o}, 32'h1);
    ticks(2);
    bwr(12'h00C, 32'h0);
    brd(12'h010); check("R10 t0 cleared", d, 32'h0);
    brd(12'h030); check("R10 t1 pending", d, 32'h1);
    check("R10 irq held by t1", {31'b0, irq_o}, 32'h1);
    bwr(12'h02C, 32'h0);
    @(negedge clk_i);
    check("R10 irq drops", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_count_ro();
    do_reset();
    bwr(12'h000, 32'd9);
    bwr(12'h004, 32'd99);
    brd(12'h004); check("R11 count write ignored", d, 32'd9);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_steer();
    t_window();
    t_latency();
    t_loads();
    t_prescale();
    t_status();
    t_modes();
    t_oneshot();
    t_merge();
    t_count_ro();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule